// File: doc/BRIEF.md
# Latency-Aware Issue Interlock

This block sits at the issue stage of an in-order, single-issue pipeline that keeps integer and floating-point registers in separate files. Each cycle the decoder presents one instruction: a class code, a destination index and two source indices. The block tracks every register that has an outstanding producer, together with that producer's class and the number of cycles since it issued. It lets the instruction issue only when each source has waited the gap that its producer/consumer class pair requires. Until then it drops its ready output and a bubble enters the pipeline.

The required gap depends on both ends of the dependence. A floating-point arithmetic result needs three cycles before another arithmetic operation may read it, but only two before it can be stored. A loaded value needs one cycle before arithmetic and none before a store. Integer results are free by default. A two-state machine follows the single branch delay slot. In `ST_RUN`, issuing a branch moves it to `ST_SLOT`. In `ST_SLOT`, the next issued instruction carries the slot flag, and the machine returns to `ST_RUN` unless that instruction is itself a branch. A counter records every bubble.

Top module: `issue_interlock`

## Requirements
- R1: With class codes 0 integer op, 1 FP arithmetic, 2 load double, 3 store double, 4 branch, 5 empty slot, an FP arithmetic op (dst = FP index, src_a and src_b = FP indices) that reads the destination of the FP arithmetic op issued just before it stalls exactly 3 cycles.
- R2: A store double (src_a = integer base, src_b = FP data) whose data is the destination of the FP arithmetic op issued just before it stalls exactly 2 cycles.
- R3: An FP arithmetic op reading the destination of a load double (dst = FP index, src_a = integer base) issued just before it stalls exactly 1 cycle.
- R4: A store of a just-loaded value stalls 0 cycles. An integer op (dst, src_a, src_b all integer) followed by a branch (src_a integer) testing its result stalls 0 cycles.
- R5: With two sources, the stall equals the largest remaining gap among them. A source with no pending producer adds nothing.
- R6: A newer producer of a register replaces the older one's class and age, so the stall follows the newest producer.
- R7: Integer and FP indices are separate: a pending FP producer of index k does not delay an integer read of index k. Integer index 0 never records a producer.
- R8: While an instruction is held, `in_ready` and `issue_valid` are low, and `stall_count` rises by one per held cycle. The source keeps the instruction unchanged until it issues.
- R9: The instruction issued right after a branch has `issue_slot` high, and only that one.
- R10: Synchronous reset clears the scoreboard and `stall_count`, so the first instruction after reset issues without stalling.
- R11: The loop load, dependent FP add, dependent store, pointer decrement, branch, empty slot repeats every 9 cycles. The order load, add, decrement, branch, with the store in the delay slot, repeats every 6 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An instruction is presented |
| in_ready | output | 1 | Presented instruction may issue this cycle |
| in_class | input | 3 | Class code (see R1) |
| in_dst | input | RW | Destination register index |
| in_src_a | input | RW | First source index |
| in_src_b | input | RW | Second source index |
| issue_valid | output | 1 | Instruction issues on this edge |
| issue_slot | output | 1 | Issuing instruction occupies a branch delay slot |
| stall_count | output | CNT_W | Number of bubbles inserted since reset |

## Verification
Assertions check, on every cycle, that a scoreboard entry never outlives its producer's longest gap and is fresh after each write. They also check that a back-to-back FP-to-FP or load-to-FP dependence is never let through, that the bubble counter steps exactly with held cycles, and that the slot flag follows a branch and then clears. The exact stall length for each class pair, the choice of the maximum among two sources, overwrite by a newer producer, the separation of the two register files, reset clearing, and the 9- and 6-cycle loop periods appear only in the bench's directed scenarios, which count issue cycles at the ports.

// File: rtl/issue_interlock_pkg.sv
package issue_interlock_pkg;

    typedef enum logic [2:0] {
        C_INT    = 3'd0,
        C_FPOP   = 3'd1,
        C_LOAD   = 3'd2,
        C_STORE  = 3'd3,
        C_BRANCH = 3'd4,
        C_NOP    = 3'd5
    } iclass_t;

    // class of the instruction that owns a pending register
    typedef enum logic [1:0] {
        P_INT = 2'd0,
        P_FP  = 2'd1,
        P_LD  = 2'd2
    } prod_t;

    // how a source operand is consumed
    typedef enum logic [1:0] {
        K_INT = 2'd0,
        K_FP  = 2'd1,
        K_ST  = 2'd2
    } kind_t;

    function automatic int gap_of(prod_t p, kind_t k,
                                  int ii, int ff, int fs, int lf, int ls);
        int g;
        unique case (p)
            P_INT:   g = ii;
            P_FP:    g = (k == K_ST) ? fs : ff;
            P_LD:    g = (k == K_ST) ? ls : lf;
            default: g = 0;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard
    import issue_interlock_pkg::*;
#(
    parameter int RW        = 5,
    parameter int CW        = 3,
    parameter int CAP_INT   = 0,
    parameter int CAP_FP    = 3,
    parameter int CAP_LD    = 1,
    parameter bit SKIP_ZERO = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_idx,
    input  prod_t         wr_cls,
    input  logic [RW-1:0] rd_idx_a,
    input  logic [RW-1:0] rd_idx_b,
    output logic          rd_pend_a,
    output logic          rd_pend_b,
    output prod_t         rd_cls_a,
    output prod_t         rd_cls_b,
    output logic [CW-1:0] rd_age_a,
    output logic [CW-1:0] rd_age_b
);

    localparam int            NREG    = 1 << RW;
    localparam logic [CW-1:0] AGE_ONE = CW'(1);

    logic          pend [NREG];
    prod_t         cls  [NREG];
    logic [CW-1:0] age  [NREG];
    logic          wr_fire;

    function automatic int cap_of(prod_t p);
        int c;
        unique case (p)
            P_INT:   c = CAP_INT;
            P_FP:    c = CAP_FP;
            P_LD:    c = CAP_LD;
            default: c = 0;
        endcase
        return c;
    endfunction

    // producers whose longest gap is zero never need an entry
    always_comb begin
        wr_fire = wr_en && (cap_of(wr_cls) > 0);
        if (SKIP_ZERO && (wr_idx == '0)) wr_fire = 1'b0;
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NREG; k++) begin
            if (rst) begin
                pend[k] <= 1'b0;
                cls[k]  <= P_INT;
                age[k]  <= '0;
            end else if (wr_fire && (wr_idx == RW'(k))) begin
                pend[k] <= 1'b1;
                cls[k]  <= wr_cls;
                age[k]  <= '0;
            end else if (pend[k]) begin
                if ((int'(age[k]) + 1) >= cap_of(cls[k])) begin
                    pend[k] <= 1'b0;
                end else begin
                    age[k] <= age[k] + AGE_ONE;
                end
            end
        end
    end

    always_comb begin
        rd_pend_a = pend[rd_idx_a];
        rd_pend_b = pend[rd_idx_b];
        if (SKIP_ZERO && (rd_idx_a == '0)) rd_pend_a = 1'b0;
        if (SKIP_ZERO && (rd_idx_b == '0)) rd_pend_b = 1'b0;
        rd_cls_a = cls[rd_idx_a];
        rd_cls_b = cls[rd_idx_b];
        rd_age_a = age[rd_idx_a];
        rd_age_b = age[rd_idx_b];
    end

    // checker state: remembers last write for the refresh check
    logic          chk_wr;
    logic [RW-1:0] chk_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_wr  <= 1'b0;
            chk_idx <= '0;
        end else begin
            chk_wr  <= wr_fire;
            chk_idx <= wr_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst) begin
            if (chk_wr) begin
                p_refresh_r6: assert (pend[chk_idx] && (age[chk_idx] == '0))
                    else $error("entry not refreshed by newer producer");
            end
            for (int k = 0; k < NREG; k++) begin
                p_age_bound_r6: assert (!pend[k] || (int'(age[k]) < cap_of(cls[k])))
                    else $error("scoreboard entry outlived its gap");
            end
        end
    end

endmodule

// File: rtl/ilk_issue_ctl.sv
module ilk_issue_ctl #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_ready,
    input  logic             is_branch,
    output logic             issue_valid,
    output logic             issue_slot,
    output logic [CNT_W-1:0] stall_count
);

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_SLOT = 1'b1
    } state_t;

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    state_t state, state_nx;
    logic   held;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (issue_valid && is_branch)  state_nx = ST_SLOT;
            ST_SLOT: if (issue_valid && !is_branch) state_nx = ST_RUN;
            default: state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        issue_valid = in_valid && in_ready;
        issue_slot  = issue_valid && (state == ST_SLOT);
        held        = in_valid && !in_ready;
    end

    always_ff @(posedge clk) begin
        if (rst)       stall_count <= '0;
        else if (held) stall_count <= stall_count + CNT_ONE;
    end

    p_stall_step_r8: assert property (@(posedge clk) disable iff (rst)
        held |=> (stall_count == $past(stall_count) + CNT_ONE));

    p_no_phantom_stall_r8: assert property (@(posedge clk) disable iff (rst)
        !held |=> $stable(stall_count));

    p_hold_kept_r8: assert property (@(posedge clk) disable iff (rst)
        held |=> in_valid);

    p_slot_follows_branch_r9: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && is_branch) |=> (state == ST_SLOT));

    p_slot_single_r9: assert property (@(posedge clk) disable iff (rst)
        (issue_slot && !is_branch) |=> !issue_slot);

endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
    import issue_interlock_pkg::*;
#(
    parameter int RW          = 5,
    parameter int LAT_FP_FP   = 3,
    parameter int LAT_FP_ST   = 2,
    parameter int LAT_LD_FP   = 1,
    parameter int LAT_LD_ST   = 0,
    parameter int LAT_INT_INT = 0,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [2:0]       in_class,
    input  logic [RW-1:0]    in_dst,
    input  logic [RW-1:0]    in_src_a,
    input  logic [RW-1:0]    in_src_b,
    output logic             issue_valid,
    output logic             issue_slot,
    output logic [CNT_W-1:0] stall_count
);

    localparam int CAP_FP  = (LAT_FP_FP > LAT_FP_ST) ? LAT_FP_FP : LAT_FP_ST;
    localparam int CAP_LD  = (LAT_LD_FP > LAT_LD_ST) ? LAT_LD_FP : LAT_LD_ST;
    localparam int CAP_INT = LAT_INT_INT;
    localparam int CAP_M1  = (CAP_FP > CAP_LD) ? CAP_FP : CAP_LD;
    localparam int CAP_MAX = (CAP_M1 > CAP_INT) ? CAP_M1 : CAP_INT;
    localparam int CW      = (CAP_MAX < 2) ? 1 : $clog2(CAP_MAX);

    iclass_t cls;
    logic    use_a, use_b, a_fp, b_fp;
    kind_t   kind_a, kind_b;
    logic    wr_int, wr_fp;
    prod_t   wr_prod;

    // operand decode per class
    always_comb begin
        cls     = iclass_t'(in_class);
        use_a   = 1'b0;
        use_b   = 1'b0;
        a_fp    = 1'b0;
        b_fp    = 1'b0;
        kind_a  = K_INT;
        kind_b  = K_INT;
        wr_int  = 1'b0;
        wr_fp   = 1'b0;
        wr_prod = P_INT;
        unique case (cls)
            C_INT: begin
                use_a  = 1'b1;
                use_b  = 1'b1;
                wr_int = 1'b1;
            end
            C_FPOP: begin
                use_a   = 1'b1;
                use_b   = 1'b1;
                a_fp    = 1'b1;
                b_fp    = 1'b1;
                kind_a  = K_FP;
                kind_b  = K_FP;
                wr_fp   = 1'b1;
                wr_prod = P_FP;
            end
            C_LOAD: begin
                use_a   = 1'b1;
                wr_fp   = 1'b1;
                wr_prod = P_LD;
            end
            C_STORE: begin
                use_a  = 1'b1;
                use_b  = 1'b1;
                b_fp   = 1'b1;
                kind_b = K_ST;
            end
            C_BRANCH: use_a = 1'b1;
            default:  ;
        endcase
    end

    logic          ip_a, ip_b, fp_pa, fp_pb;
    prod_t         ic_a, ic_b, fc_a, fc_b;
    logic [CW-1:0] ia_a, ia_b, fa_a, fa_b;

    ilk_scoreboard #(
        .RW(RW), .CW(CW), .CAP_INT(CAP_INT), .CAP_FP(CAP_FP),
        .CAP_LD(CAP_LD), .SKIP_ZERO(1'b1)
    ) int_sb_i (
        .clk(clk), .rst(rst),
        .wr_en(issue_valid && wr_int), .wr_idx(in_dst), .wr_cls(wr_prod),
        .rd_idx_a(in_src_a), .rd_idx_b(in_src_b),
        .rd_pend_a(ip_a), .rd_pend_b(ip_b),
        .rd_cls_a(ic_a), .rd_cls_b(ic_b),
        .rd_age_a(ia_a), .rd_age_b(ia_b)
    );

    ilk_scoreboard #(
        .RW(RW), .CW(CW), .CAP_INT(CAP_INT), .CAP_FP(CAP_FP),
        .CAP_LD(CAP_LD), .SKIP_ZERO(1'b0)
    ) fp_sb_i (
        .clk(clk), .rst(rst),
        .wr_en(issue_valid && wr_fp), .wr_idx(in_dst), .wr_cls(wr_prod),
        .rd_idx_a(in_src_a), .rd_idx_b(in_src_b),
        .rd_pend_a(fp_pa), .rd_pend_b(fp_pb),
        .rd_cls_a(fc_a), .rd_cls_b(fc_b),
        .rd_age_a(fa_a), .rd_age_b(fa_b)
    );

    logic          pend_a, pend_b, blk_a, blk_b;
    prod_t         pc_a, pc_b;
    logic [CW-1:0] age_a, age_b;
    int            gap_a, gap_b;

    // each source is blocked while its producer's gap is still open
    always_comb begin
        pend_a = a_fp ? fp_pa : ip_a;
        pc_a   = a_fp ? fc_a  : ic_a;
        age_a  = a_fp ? fa_a  : ia_a;
        pend_b = b_fp ? fp_pb : ip_b;
        pc_b   = b_fp ? fc_b  : ic_b;
        age_b  = b_fp ? fa_b  : ia_b;
        gap_a  = gap_of(pc_a, kind_a, LAT_INT_INT, LAT_FP_FP, LAT_FP_ST,
                        LAT_LD_FP, LAT_LD_ST);
        gap_b  = gap_of(pc_b, kind_b, LAT_INT_INT, LAT_FP_FP, LAT_FP_ST,
                        LAT_LD_FP, LAT_LD_ST);
        blk_a  = use_a && pend_a && (int'(age_a) < gap_a);
        blk_b  = use_b && pend_b && (int'(age_b) < gap_b);
        in_ready = !(blk_a || blk_b);
    end

    ilk_issue_ctl #(.CNT_W(CNT_W)) ctl_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .is_branch(cls == C_BRANCH),
        .issue_valid(issue_valid), .issue_slot(issue_slot),
        .stall_count(stall_count)
    );

    p_fpfp_gap_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(issue_valid) && ($past(in_class) == 3'd1) &&
         in_valid && (in_class == 3'd1) &&
         ((in_src_a == $past(in_dst)) || (in_src_b == $past(in_dst))))
        |-> !in_ready);

    p_ldfp_gap_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(issue_valid) && ($past(in_class) == 3'd2) &&
         in_valid && (in_class == 3'd1) &&
         ((in_src_a == $past(in_dst)) || (in_src_b == $past(in_dst))))
        |-> !in_ready);

endmodule

// File: tb/issue_interlock_tb_top.sv
module issue_interlock_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_class = 3'd5;
    logic [4:0]  in_dst = '0;
    logic [4:0]  in_src_a = '0;
    logic [4:0]  in_src_b = '0;
    logic        issue_valid;
    logic        issue_slot;
    logic [15:0] stall_count;

    int vectors = 0;
    int misses  = 0;
    int cyc     = 0;
    int last_issue_cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    issue_interlock dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_class(in_class), .in_dst(in_dst), .in_src_a(in_src_a),
        .in_src_b(in_src_b), .issue_valid(issue_valid),
        .issue_slot(issue_slot), .stall_count(stall_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // drive at negedge, sample 1 ns later, wait until it issues
    task automatic send(input int c, input int d, input int a, input int b,
                        output int stalls, output bit slot);
        in_valid = 1'b1;
        in_class = 3'(c);
        in_dst   = 5'(d);
        in_src_a = 5'(a);
        in_src_b = 5'(b);
        stalls   = 0;
        #1;
        while (!in_ready) begin
            if (issue_valid) chk(1'b0, "R8 issue while held", 1, 0);
            stalls++;
            @(negedge clk);
            #1;
        end
        slot = issue_slot;
        last_issue_cyc = cyc;
        if (!issue_valid) chk(1'b0, "R8 issue_valid with ready", 0, 1);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        in_class = 3'd5;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        int s; bit sl;
        do_reset();
        #1;
        chk(stall_count == 16'd0, "R10 counter after reset", int'(stall_count), 0);
        chk(issue_valid == 1'b0, "R10 no issue while idle", int'(issue_valid), 0);
        @(negedge clk);
        send(1, 1, 2, 3, s, sl);
        // reset right after a producer: its entry must vanish
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        send(1, 4, 1, 1, s, sl);
        chk(s == 0, "R10 first instr after reset", s, 0);
        chk(stall_count == 16'd0, "R10 counter cleared", int'(stall_count), 0);
        idle(4);
    endtask

    task automatic t_fp_fp();
        int s; bit sl; int c0;
        c0 = int'(stall_count);
        send(1, 1, 2, 3, s, sl);
        in_valid = 1'b1; in_class = 3'd1; in_dst = 5'd3; in_src_a = 5'd1; in_src_b = 5'd2;
        #1;
        chk(in_ready == 1'b0 && issue_valid == 1'b0, "R8 held outputs low",
            int'(in_ready), 0);
        @(negedge clk);
        send(1, 3, 1, 2, s, sl);
        chk(s == 2, "R1 remaining fp-fp stalls", s + 1, 3);
        chk(int'(stall_count) - c0 == 3, "R8 bubble count", int'(stall_count) - c0, 3);
        idle(4);
    endtask

    task automatic t_fp_st();
        int s; bit sl;
        send(1, 5, 2, 3, s, sl);
        send(3, 0, 2, 5, s, sl);
        chk(s == 2, "R2 fp-store stalls", s, 2);
        idle(4);
    endtask

    task automatic t_ld_fp();
        int s; bit sl;
        send(2, 6, 1, 0, s, sl);
        send(1, 7, 6, 2, s, sl);
        chk(s == 1, "R3 load-fp stalls", s, 1);
        idle(4);
    endtask

    task automatic t_zero_gaps();
        int s; bit sl;
        send(2, 7, 1, 0, s, sl);
        send(3, 0, 2, 7, s, sl);
        chk(s == 0, "R4 load-store stalls", s, 0);
        send(0, 3, 1, 2, s, sl);
        send(4, 0, 3, 0, s, sl);
        chk(s == 0, "R4 int-branch stalls", s, 0);
        send(5, 0, 0, 0, s, sl);
        chk(sl == 1'b1, "R9 slot flagged", int'(sl), 1);
        send(0, 4, 1, 2, s, sl);
        chk(sl == 1'b0, "R9 next not flagged", int'(sl), 0);
        idle(4);
    endtask

    task automatic t_multi();
        int s; bit sl;
        send(2, 8, 1, 0, s, sl);
        send(1, 9, 2, 3, s, sl);
        chk(s == 0, "R5 sources idle", s, 0);
        send(1, 10, 8, 9, s, sl);
        chk(s == 3, "R5 max of two gaps", s, 3);
        idle(4);
    endtask

    task automatic t_rewrite();
        int s; bit sl;
        send(1, 11, 2, 3, s, sl);
        send(2, 11, 1, 0, s, sl);
        send(1, 12, 11, 2, s, sl);
        chk(s == 1, "R6 newest producer rules", s, 1);
        idle(4);
    endtask

    task automatic t_spaces();
        int s; bit sl;
        send(1, 4, 2, 3, s, sl);
        send(0, 5, 4, 4, s, sl);
        chk(s == 0, "R7 int read of fp index", s, 0);
        send(3, 0, 4, 1, s, sl);
        chk(s == 0, "R7 store base of fp index", s, 0);
        // writes to integer index 0 leave the FP index 0 free
        send(0, 0, 1, 2, s, sl);
        send(1, 13, 0, 2, s, sl);
        chk(s == 0, "R7 int r0 leaves fp 0 free", s, 0);
        idle(4);
    endtask

    task automatic t_loops();
        int s; bit sl; int t0;
        // plain order
        send(2, 0, 1, 0, s, sl);
        t0 = last_issue_cyc;
        send(1, 4, 0, 2, s, sl);
        send(3, 0, 1, 4, s, sl);
        send(0, 1, 1, 0, s, sl);
        send(4, 0, 1, 0, s, sl);
        send(5, 0, 0, 0, s, sl);
        send(2, 0, 1, 0, s, sl);
        chk(last_issue_cyc - t0 == 9, "R11 plain loop period", last_issue_cyc - t0, 9);
        idle(4);
        // reordered with the store in the slot
        send(2, 0, 1, 0, s, sl);
        t0 = last_issue_cyc;
        send(1, 4, 0, 2, s, sl);
        send(0, 1, 1, 0, s, sl);
        send(4, 0, 1, 0, s, sl);
        send(3, 0, 1, 4, s, sl);
        chk(sl == 1'b1, "R9 store in slot", int'(sl), 1);
        send(2, 0, 1, 0, s, sl);
        chk(last_issue_cyc - t0 == 6, "R11 scheduled loop period", last_issue_cyc - t0, 6);
        idle(4);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_fp_fp();
        t_fp_st();
        t_ld_fp();
        t_zero_gaps();
        t_multi();
        t_rewrite();
        t_spaces();
        t_loops();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule